// File: doc/BRIEF.md
# Long Maximal-Length XNOR Shift Sequence Generator

This block produces a pseudo-random bit stream from a single Fibonacci shift register that is longer than 64 stages. The stage count is fixed when the block is built and may be 65, 68 or 71. The block works out the one matching feedback tap by itself. Each enabled clock moves every stage one place toward the far end. The empty first stage then takes the inverted exclusive-or of the last stage and the tap stage. For every supported length this gives a sequence of 2^n - 1 states.

Stages are numbered from 1 at the input end to n at the output end. Bit i of the state port holds stage i+1. Because the feedback is an XNOR, the dead state is the one with every stage at one. The all-zero state is an ordinary member of the sequence. Reset therefore clears the register. A seed load that asks for the dead state is turned into all zeros. A caller can restart the sequence at any point by strobing a seed in, and can pause it with the enable.

Top module: `lfsr_xnor_long`

## Requirements
- R1: A high synchronous reset clears every stage to 0 at the next clock edge. Reset wins over load and enable.
- R2: With reset low and load high, the register takes the seed value at the next edge. Bit i of the seed goes to stage i+1. Load wins over enable.
- R3: A load whose seed has every one of the LEN bits set leaves the register all zeros instead.
- R4: With reset, load and enable all low, the state does not change.
- R5: With enable high and reset and load low, stage k+1 takes the old stage k for k = 1..LEN-1. Stage 1 takes NOT(stage LEN XOR stage TAP). In port terms this is state <= {state[LEN-2:0], ~(state[LEN-1] ^ state[TAP-1])}.
- R6: The tap follows the length: TAP = 47 for LEN = 65, 59 for LEN = 68, and 65 for LEN = 71.
- R7: The serial output is stage LEN, which is bit LEN-1 of the state port.
- R8: Once reset has been applied, the register never holds the all-ones state.
- R9: Any LEN other than 65, 68 or 71 stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears all stages |
| en | input | 1 | Step enable; shifts one place when high |
| load | input | 1 | Seed strobe; copies the seed in, ahead of en |
| seed | input | LEN | Seed value; bit i goes to stage i+1 |
| dout | output | 1 | Serial output, the last stage |
| state | output | LEN | Full register contents; bit i is stage i+1 |

## Verification
The hardest condition to reach is the edge of the dead state. A register started from zero would need on the order of 2^65 steps to come near it. The stimulus goes there directly. It loads seeds that are all ones except one stage, including the stages at the tap and at the output end, then shifts from them, and it also loads the all-ones seed with enable high. Random runs mix seed loads, pauses and rare resets. The same inputs drive all three lengths at once, so each tap choice is tested against a separate reference model in the bench.

// File: rtl/lfsr_xnor_pkg.sv
package lfsr_xnor_pkg;

   // Per-cycle action chosen for every stage of the register.
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_SHIFT = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } lfsr_op_e;

   // R6: second feedback stage (numbered 1..n) for each supported length.
   // An unsupported length returns 0, which the top rejects (R9).
   function automatic int tap_of(input int n);
      case (n)
         65:      return 47;
         68:      return 59;
         71:      return 65;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/lfsr_op_decode.sv
module lfsr_op_decode
   import lfsr_xnor_pkg::*;
(
   input  logic     rst,
   input  logic     load,
   input  logic     en,
   output lfsr_op_e op
);

   // Priority order: reset, then seed load, then step, else hold.
   always_comb begin
      if (rst)
         op = OP_CLEAR;
      else if (load)
         op = OP_LOAD;
      else if (en)
         op = OP_SHIFT;
      else
         op = OP_HOLD;
   end

endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
   parameter int LEN = 65
) (
   input  logic [LEN-1:0] seed_in,
   output logic [LEN-1:0] seed_safe
);

   logic dead_seed;

   // The all-ones word can never leave itself under XNOR feedback.
   assign dead_seed = &seed_in;
   assign seed_safe = dead_seed ? '0 : seed_in;

endmodule

// File: rtl/lfsr_fb_xnor.sv
module lfsr_fb_xnor (
   input  logic last_stage,
   input  logic tap_stage,
   output logic fb
);

   assign fb = ~(last_stage ^ tap_stage);

endmodule

// File: rtl/lfsr_stage_bank.sv
module lfsr_stage_bank
   import lfsr_xnor_pkg::*;
#(
   parameter int LEN = 65
) (
   input  logic           clk,
   input  lfsr_op_e       op,
   input  logic           fb,
   input  logic [LEN-1:0] seed_safe,
   output logic [LEN-1:0] q
);

   // One flop per stage. Stage 1 (bit 0) takes the feedback when
   // shifting; every other stage takes its lower neighbour.
   for (genvar i = 0; i < LEN; i++) begin : g_stage
      logic shift_src;

      if (i == 0) begin : g_head
         assign shift_src = fb;
      end else begin : g_body
         assign shift_src = q[i-1];
      end

      always_ff @(posedge clk) begin
         case (op)
            OP_CLEAR: q[i] <= 1'b0;
            OP_LOAD:  q[i] <= seed_safe[i];
            OP_SHIFT: q[i] <= shift_src;
            default:  q[i] <= q[i];
         endcase
      end
   end

endmodule

// File: rtl/lfsr_xnor_long.sv
module lfsr_xnor_long
   import lfsr_xnor_pkg::*;
#(
   parameter int LEN = 65
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           en,
   input  logic           load,
   input  logic [LEN-1:0] seed,
   output logic           dout,
   output logic [LEN-1:0] state
);

   localparam int TAP     = tap_of(LEN);
   localparam int TAP_IDX = (TAP > 0) ? TAP - 1 : 0;

   // R9: only the lengths with a known maximal tap are accepted.
   if (TAP == 0) begin : g_bad_len
      $error("lfsr_xnor_long: LEN=%0d has no maximal XNOR tap (use 65, 68 or 71)", LEN);
   end

   lfsr_op_e       op;
   logic           fb;
   logic [LEN-1:0] seed_safe;
   logic [LEN-1:0] state_q;

   lfsr_op_decode u_dec (
      .rst  (rst),
      .load (load),
      .en   (en),
      .op   (op)
   );

   lfsr_seed_guard #(.LEN(LEN)) u_guard (
      .seed_in   (seed),
      .seed_safe (seed_safe)
   );

   lfsr_fb_xnor u_fb (
      .last_stage (state_q[LEN-1]),
      .tap_stage  (state_q[TAP_IDX]),
      .fb         (fb)
   );

   lfsr_stage_bank #(.LEN(LEN)) u_bank (
      .clk       (clk),
      .op        (op),
      .fb        (fb),
      .seed_safe (seed_safe),
      .q         (state_q)
   );

   assign state = state_q;
   assign dout  = state_q[LEN-1];

endmodule

// File: rtl/lfsr_xnor_long_chk.sv
module lfsr_xnor_long_chk #(
   parameter int LEN = 65,
   parameter int TAP = 47
) (
   input logic           clk,
   input logic           rst,
   input logic           en,
   input logic           load,
   input logic [LEN-1:0] seed,
   input logic           dout,
   input logic [LEN-1:0] state
);

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (state == '0));

   a_r2_seed_taken: assert property (@(posedge clk) disable iff (rst)
      (load && !(&seed)) |=> (state == $past(seed)));

   a_r3_dead_seed_blocked: assert property (@(posedge clk) disable iff (rst)
      (load && (&seed)) |=> (state == '0));

   a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
      (!load && !en) |=> $stable(state));

   a_r5_shift_step: assert property (@(posedge clk) disable iff (rst)
      (!load && en) |=> ((state[LEN-1:1] == $past(state[LEN-2:0])) &&
                         (state[0] == ~($past(state[LEN-1]) ^ $past(state[TAP-1])))));

   a_r7_serial_tracks: assert property (@(posedge clk) disable iff (rst)
      (!load && en) |=> (dout == $past(state[LEN-2])));

   a_r8_no_lockup: assert property (@(posedge clk) disable iff (rst)
      !(&state));

endmodule

bind lfsr_xnor_long lfsr_xnor_long_chk #(.LEN(LEN), .TAP(TAP)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .en    (en),
   .load  (load),
   .seed  (seed),
   .dout  (dout),
   .state (state)
);

// File: tb/sim_lfsr_xnor_long.sv
module sim_lfsr_xnor_long;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en = 1'b0;
   logic        load = 1'b0;
   logic [70:0] seed_drv = '0;

   logic [64:0] st65;
   logic [67:0] st68;
   logic [70:0] st71;
   logic        d65, d68, d71;

   logic [70:0] m65 = '0;
   logic [70:0] m68 = '0;
   logic [70:0] m71 = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   lfsr_xnor_long #(.LEN(65)) u0 (
      .clk(clk), .rst(rst), .en(en), .load(load),
      .seed(seed_drv[64:0]), .dout(d65), .state(st65));

   lfsr_xnor_long #(.LEN(68)) u1 (
      .clk(clk), .rst(rst), .en(en), .load(load),
      .seed(seed_drv[67:0]), .dout(d68), .state(st68));

   lfsr_xnor_long #(.LEN(71)) u2 (
      .clk(clk), .rst(rst), .en(en), .load(load),
      .seed(seed_drv[70:0]), .dout(d71), .state(st71));

   // R6 taps as the bench expects them
   function automatic int bench_tap(input int n);
      if (n == 65) return 47;
      if (n == 68) return 59;
      return 65;
   endfunction

   function automatic logic [70:0] mask_of(input int n);
      logic [70:0] m;
      m = '0;
      for (int i = 0; i < n; i++) m[i] = 1'b1;
      return m;
   endfunction

   function automatic logic [70:0] ref_next(input logic [70:0] s, input int n,
                                            input bit r, input bit l, input bit e,
                                            input logic [70:0] sd);
      logic [70:0] m;
      logic [70:0] sdm;
      logic        f;
      m = mask_of(n);
      if (r) return '0;
      if (l) begin
         sdm = sd & m;
         return (sdm == m) ? '0 : sdm;
      end
      if (e) begin
         f = ~(s[n-1] ^ s[bench_tap(n)-1]);
         return ((s << 1) | {70'd0, f}) & m;
      end
      return s;
   endfunction

   task automatic check_val(input string tag, input int n,
                            input logic [70:0] act, input logic [70:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s len=%0d actual=%h expected=%h", tag, n, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      check_val(tag, 65, {6'd0, st65}, m65);
      check_val(tag, 68, {3'd0, st68}, m68);
      check_val(tag, 71, st71, m71);
      check_val("R7", 65, {70'd0, d65}, {70'd0, m65[64]});
      check_val("R7", 68, {70'd0, d68}, {70'd0, m68[67]});
      check_val("R7", 71, {70'd0, d71}, {70'd0, m71[70]});
      check_val("R8", 65, {70'd0, &st65}, '0);
      check_val("R8", 68, {70'd0, &st68}, '0);
      check_val("R8", 71, {70'd0, &st71}, '0);
   endtask

   task automatic step(input bit r, input bit l, input bit e,
                       input logic [70:0] sd, input string tag);
      @(negedge clk);
      rst = r; load = l; en = e; seed_drv = sd;
      @(posedge clk);
      #1;
      m65 = ref_next(m65, 65, r, l, e, sd);
      m68 = ref_next(m68, 68, r, l, e, sd);
      m71 = ref_next(m71, 71, r, l, e, sd);
      check_all(tag);
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   function automatic logic [70:0] rand_word();
      return 71'({$urandom(), $urandom(), $urandom()});
   endfunction

   initial begin
      void'($urandom(32'd2024));

      // R1: reset clears, also when load and enable are high
      step(1, 0, 0, {71{1'b1}}, "R1");
      step(1, 1, 1, rand_word(), "R1");

      // R5: one step from zero gives stage 1 = 1
      step(0, 0, 1, '0, "R5");
      check_val("R5", 65, {6'd0, st65}, 71'd1);

      // R6: seed with the tap stage set, then step
      step(0, 1, 0, (71'd1 << 46) | (71'd1 << 58) | (71'd1 << 64), "R6");
      step(0, 0, 1, '0, "R6");
      step(0, 0, 1, '0, "R6");

      // R3: all-ones seed, with enable low and high
      step(0, 1, 0, {71{1'b1}}, "R3");
      check_val("R3", 71, st71, '0);
      step(0, 1, 1, {71{1'b1}}, "R3");

      // R2: plain load, then load ahead of enable
      step(0, 1, 0, 71'h2A_5555_AAAA_1234_5678, "R2");
      step(0, 1, 1, 71'h15_0F0F_F0F0_8765_4321, "R2");

      // R4: idle cycles hold the state
      for (int k = 0; k < 3; k++) step(0, 0, 0, rand_word(), "R4");

      // R8: seeds one step away from the dead state, then shift
      foreach (m65[b]) begin
         if (b == 0 || b == 46 || b == 58 || b == 64 || b == 70) begin
            step(0, 1, 0, ~(71'd1 << b), "R8");
            for (int k = 0; k < 4; k++) step(0, 0, 1, '0, "R8");
         end
      end

      // Random mix
      for (int k = 0; k < 4000; k++) begin
         int unsigned pick;
         logic [70:0] sd;
         pick = $urandom_range(0, 255);
         sd = rand_word();
         if ($urandom_range(0, 7) == 0) sd = ~(71'd1 << $urandom_range(0, 70));
         if ($urandom_range(0, 15) == 0) sd = {71{1'b1}};
         step(pick == 0, pick < 9, $urandom_range(0, 3) != 0, sd, "R5");
      end

      done = 1'b1;
      report();
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R5 actual=running expected=finished");
         report();
         $finish;
      end
   end

endmodule